// File: doc/BRIEF.md
# Return Address Stack Controller

This block keeps the return addresses of an 8-bit processor in an on-chip stack of eight 15-bit entries. Subroutine calls of every form (on a condition, on a non-zero register, relative to page zero, indexed) push the address that follows the call. Conditional returns pop the most recent address and hand it to the program counter logic. One return form also lifts the interrupt inhibit. The 3-bit stack pointer lives in the low bits of the upper status byte, so it is always visible, and status-byte loads can overwrite it.

The block also runs interrupt entry. When the active-low interrupt line is seen at an instruction boundary while the inhibit flag is clear, the block sets the inhibit flag. It pushes the return address and forces a jump into page zero, using the vector byte taken from the data bus as a relative displacement from address 0. A vector of 3 therefore lands at 0x0003. After reset it requests a jump to address 0 with an empty pointer and a clear inhibit flag. Branch-condition evaluation and instruction fetch are handled elsewhere.

In any one cycle the block carries out at most one operation, chosen by a fixed priority. A status load comes first, then a call, then a return, then interrupt entry. Every result is registered.

Top module: `ras_ctrl`

## Requirements
- R1: While reset is held, and up to the first clock edge after it is released, `sp_o` is 0, `inh_o` is 0, `jmp_vld_o` is 1, `jmp_addr_o` is 0, and `ret_vld_o` and `irq_ack_o` are 0.
- R2: A call increments the pointer and then writes `link_addr_i` into the entry the new pointer selects. A return reads the entry the current pointer selects and then decrements the pointer. On the cycle after a return, `ret_vld_o` is 1 and `ret_addr_o` holds the entry that was read.
- R3: The pointer wraps modulo 8 in both directions without any error indication. A push at pointer 7 writes entry 0, and a pop at pointer 0 reads entry 0 and leaves the pointer at 7.
- R4: A return with `ret_en_i` set clears the inhibit flag on the next cycle. A return with `ret_en_i` clear leaves the flag unchanged.
- R5: An interrupt is accepted only in a cycle with `irq_n_i` low, the inhibit flag clear, `instr_done_i` high, and no status load, call or return. On the next cycle, acceptance shows `irq_ack_o`=1, `jmp_vld_o`=1, `inh_o`=1, and the pointer advanced with `link_addr_i` pushed as for a call.
- R6: The interrupt jump target is `{2'b00, 13-bit sign extension of vec_i[6:0]}`, so vector 0x03 gives 0x0003 and vector 0x40 gives 0x1FC0. `vec_i[7]` has no effect on the target.
- R7: A status load sets the pointer to `sts_sp_i` and the inhibit flag to `sts_inh_i` on the next cycle. A call, return or interrupt presented in the same cycle is ignored and writes no entry.
- R8: When call and return are requested together, the call is performed and the return is ignored (`ret_vld_o` stays 0).
- R9: `ret_vld_o`, `jmp_vld_o` and `irq_ack_o` are single-cycle results and are 0 on any cycle that does not follow a return or an accepted interrupt (outside R1). `ret_addr_o` and `jmp_addr_o` hold their last value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_req_i | input | 1 | Call: push `link_addr_i` |
| ret_req_i | input | 1 | Return: pop an entry |
| ret_en_i | input | 1 | With a return: also clear the inhibit flag |
| link_addr_i | input | 15 | Return address to push (call or interrupt) |
| irq_n_i | input | 1 | Interrupt request, active low |
| instr_done_i | input | 1 | Current instruction completes this cycle |
| vec_i | input | 8 | Vector byte from the data bus |
| sts_wr_i | input | 1 | Status load of pointer and inhibit flag |
| sts_sp_i | input | 3 | Pointer value for the status load |
| sts_inh_i | input | 1 | Inhibit value for the status load |
| sp_o | output | 3 | Current stack pointer |
| inh_o | output | 1 | Interrupt inhibit flag |
| ret_vld_o | output | 1 | Popped address is valid this cycle |
| ret_addr_o | output | 15 | Popped return address |
| jmp_vld_o | output | 1 | Forced jump request (reset or interrupt) |
| jmp_addr_o | output | 15 | Forced jump target |
| irq_ack_o | output | 1 | Interrupt was accepted |

## Verification
Every result of this block is due exactly one clock edge after the edge that samples its request. This covers the pointer and inhibit updates, the popped address, and the interrupt acknowledge with its jump target. The one exception is the reset jump request, which is present from reset until the first edge after release. The bench drives a request on the falling edge, moves its model forward by one operation under the same priority, and compares every output one nanosecond after the next rising edge. A value is therefore always read in the cycle it becomes due and before the next request. Randomized traffic is mixed with directed sequences for wrap-around, ignored requests, priority and the vector arithmetic.

// File: rtl/ras_pkg.sv
package ras_pkg;
   typedef enum logic [2:0] {
      RAS_IDLE = 3'd0,
      RAS_LOAD = 3'd1,
      RAS_CALL = 3'd2,
      RAS_RET  = 3'd3,
      RAS_IRQ  = 3'd4
   } ras_op_e;
endpackage

// File: rtl/ras_arb.sv
// Picks the single operation of the cycle: load > call > return > interrupt.
module ras_arb
   import ras_pkg::*;
(
   input  logic    sts_wr_i,
   input  logic    call_req_i,
   input  logic    ret_req_i,
   input  logic    irq_take_i,
   output ras_op_e op_o
);
   always_comb begin
      if (sts_wr_i)        op_o = RAS_LOAD;
      else if (call_req_i) op_o = RAS_CALL;
      else if (ret_req_i)  op_o = RAS_RET;
      else if (irq_take_i) op_o = RAS_IRQ;
      else                 op_o = RAS_IDLE;
   end
endmodule

// File: rtl/ras_ptr.sv
// Stack pointer: natural modulo-2^PTR_W wrap in both directions.
module ras_ptr
   import ras_pkg::*;
#(
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ras_op_e          op_i,
   input  logic [PTR_W-1:0] load_val_i,
   output logic [PTR_W-1:0] ptr_o,
   output logic [PTR_W-1:0] ptr_inc_o
);
   logic [PTR_W-1:0] ptr_q;

   assign ptr_o     = ptr_q;
   assign ptr_inc_o = ptr_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else begin
         unique case (op_i)
            RAS_LOAD:          ptr_q <= load_val_i;
            RAS_CALL, RAS_IRQ: ptr_q <= ptr_inc_o;
            RAS_RET:           ptr_q <= ptr_q - 1'b1;
            default:           ptr_q <= ptr_q;
         endcase
      end
   end
endmodule

// File: rtl/ras_store.sv
// Entry array with per-entry write enables and a combinational read port.
module ras_store #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 15,
   parameter int PTR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [PTR_W-1:0]  wr_idx_i,
   input  logic [ADDR_W-1:0] wr_data_i,
   input  logic [PTR_W-1:0]  rd_idx_i,
   output logic [ADDR_W-1:0] rd_data_o
);
   logic [ADDR_W-1:0] ent_q [DEPTH];
   logic [DEPTH-1:0]  we;

   for (genvar g = 0; g < DEPTH; g++) begin : g_we
      assign we[g] = wr_en_i && (wr_idx_i == PTR_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (we[i]) ent_q[i] <= wr_data_i;
         end
      end
   end

   assign rd_data_o = ent_q[rd_idx_i];
endmodule

// File: rtl/ras_vec.sv
// Interrupt target: vector low bits as a signed displacement from address 0,
// confined to page zero.
module ras_vec #(
   parameter int ADDR_W = 15,
   parameter int PAGE_W = 13,
   parameter int DISP_W = 7,
   parameter int VEC_W  = 8
) (
   input  logic [VEC_W-1:0]  vec_i,
   output logic [ADDR_W-1:0] target_o
);
   localparam int EXT_W = PAGE_W - DISP_W;
   localparam int TOP_W = ADDR_W - PAGE_W;

   logic [DISP_W-1:0] disp;
   assign disp = vec_i[DISP_W-1:0];

   if (TOP_W > 0) begin : g_paged
      assign target_o = {{TOP_W{1'b0}}, {EXT_W{disp[DISP_W-1]}}, disp};
   end else begin : g_flat
      assign target_o = {{EXT_W{disp[DISP_W-1]}}, disp};
   end
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
   import ras_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 15,
   parameter int PAGE_W = 13,
   parameter int DISP_W = 7,
   parameter int VEC_W  = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_req_i,
   input  logic              ret_req_i,
   input  logic              ret_en_i,
   input  logic [ADDR_W-1:0] link_addr_i,
   input  logic              irq_n_i,
   input  logic              instr_done_i,
   input  logic [VEC_W-1:0]  vec_i,
   input  logic              sts_wr_i,
   input  logic [PTR_W-1:0]  sts_sp_i,
   input  logic              sts_inh_i,
   output logic [PTR_W-1:0]  sp_o,
   output logic              inh_o,
   output logic              ret_vld_o,
   output logic [ADDR_W-1:0] ret_addr_o,
   output logic              jmp_vld_o,
   output logic [ADDR_W-1:0] jmp_addr_o,
   output logic              irq_ack_o
);
   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_chk_depth
      $error("ras_ctrl: DEPTH must be a power of two of at least 2");
   end
   if (PAGE_W > ADDR_W || DISP_W >= PAGE_W) begin : g_chk_page
      $error("ras_ctrl: need DISP_W < PAGE_W <= ADDR_W");
   end
   if (DISP_W > VEC_W) begin : g_chk_vec
      $error("ras_ctrl: vector narrower than displacement");
   end

   ras_op_e           op;
   logic              inh_q;
   logic              irq_take;
   logic [PTR_W-1:0]  ptr, ptr_inc;
   logic [ADDR_W-1:0] rd_data, vec_tgt;
   logic              ret_vld_q, jmp_vld_q, ack_q;
   logic [ADDR_W-1:0] ret_addr_q, jmp_addr_q;

   assign irq_take = !irq_n_i && !inh_q && instr_done_i;

   ras_arb u_arb (
      .sts_wr_i   (sts_wr_i),
      .call_req_i (call_req_i),
      .ret_req_i  (ret_req_i),
      .irq_take_i (irq_take),
      .op_o       (op)
   );

   ras_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (op),
      .load_val_i (sts_sp_i),
      .ptr_o      (ptr),
      .ptr_inc_o  (ptr_inc)
   );

   ras_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (op == RAS_CALL || op == RAS_IRQ),
      .wr_idx_i  (ptr_inc),
      .wr_data_i (link_addr_i),
      .rd_idx_i  (ptr),
      .rd_data_o (rd_data)
   );

   ras_vec #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DISP_W(DISP_W), .VEC_W(VEC_W)) u_vec (
      .vec_i    (vec_i),
      .target_o (vec_tgt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inh_q <= 1'b0;
      end else begin
         unique case (op)
            RAS_LOAD: inh_q <= sts_inh_i;
            RAS_IRQ:  inh_q <= 1'b1;
            RAS_RET:  inh_q <= ret_en_i ? 1'b0 : inh_q;
            default:  inh_q <= inh_q;
         endcase
      end
   end

   // Result registers; reset leaves a pending jump to address 0.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_vld_q  <= 1'b0;
         ret_addr_q <= '0;
         jmp_vld_q  <= 1'b1;
         jmp_addr_q <= '0;
         ack_q      <= 1'b0;
      end else begin
         ret_vld_q <= (op == RAS_RET);
         jmp_vld_q <= (op == RAS_IRQ);
         ack_q     <= (op == RAS_IRQ);
         if (op == RAS_RET) ret_addr_q <= rd_data;
         if (op == RAS_IRQ) jmp_addr_q <= vec_tgt;
      end
   end

   assign sp_o       = ptr;
   assign inh_o      = inh_q;
   assign ret_vld_o  = ret_vld_q;
   assign ret_addr_o = ret_addr_q;
   assign jmp_vld_o  = jmp_vld_q;
   assign jmp_addr_o = jmp_addr_q;
   assign irq_ack_o  = ack_q;
endmodule

// File: rtl/ras_ctrl_chk.sv
module ras_ctrl_chk #(
   parameter int ADDR_W = 15,
   parameter int PAGE_W = 13,
   parameter int PTR_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              call_req_i,
   input logic              ret_req_i,
   input logic              ret_en_i,
   input logic              irq_n_i,
   input logic              instr_done_i,
   input logic              sts_wr_i,
   input logic [PTR_W-1:0]  sts_sp_i,
   input logic              sts_inh_i,
   input logic [PTR_W-1:0]  sp_o,
   input logic              inh_o,
   input logic              ret_vld_o,
   input logic              jmp_vld_o,
   input logic [ADDR_W-1:0] jmp_addr_o,
   input logic              irq_ack_o
);
   assert_push_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts_wr_i && call_req_i) |=> (sp_o == PTR_W'($past(sp_o) + 1'b1)));

   assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts_wr_i && !call_req_i && ret_req_i) |=> (ret_vld_o && sp_o == PTR_W'($past(sp_o) - 1'b1)));

   assert_rete_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts_wr_i && !call_req_i && ret_req_i && ret_en_i) |=> !inh_o);

   assert_irq_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts_wr_i && !call_req_i && !ret_req_i && !irq_n_i && !inh_o && instr_done_i)
      |=> (irq_ack_o && jmp_vld_o && inh_o));

   assert_irq_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      inh_o |=> !irq_ack_o);

   assert_page_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack_o |-> (jmp_addr_o[ADDR_W-1:PAGE_W] == '0));

   assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sts_wr_i |=> (sp_o == $past(sts_sp_i) && inh_o == $past(sts_inh_i) && !ret_vld_o && !irq_ack_o));

   assert_call_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts_wr_i && call_req_i && ret_req_i) |=> !ret_vld_o);
endmodule

bind ras_ctrl ras_ctrl_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PTR_W(PTR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .call_req_i   (call_req_i),
   .ret_req_i    (ret_req_i),
   .ret_en_i     (ret_en_i),
   .irq_n_i      (irq_n_i),
   .instr_done_i (instr_done_i),
   .sts_wr_i     (sts_wr_i),
   .sts_sp_i     (sts_sp_i),
   .sts_inh_i    (sts_inh_i),
   .sp_o         (sp_o),
   .inh_o        (inh_o),
   .ret_vld_o    (ret_vld_o),
   .jmp_vld_o    (jmp_vld_o),
   .jmp_addr_o   (jmp_addr_o),
   .irq_ack_o    (irq_ack_o)
);

// File: tb/tb_ras_ctrl.sv
`timescale 1ns/1ps
module tb_ras_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        call_req_i = 0, ret_req_i = 0, ret_en_i = 0;
   logic [14:0] link_addr_i = '0;
   logic        irq_n_i = 1, instr_done_i = 0;
   logic [7:0]  vec_i = '0;
   logic        sts_wr_i = 0;
   logic [2:0]  sts_sp_i = '0;
   logic        sts_inh_i = 0;
   logic [2:0]  sp_o;
   logic        inh_o, ret_vld_o, jmp_vld_o, irq_ack_o;
   logic [14:0] ret_addr_o, jmp_addr_o;

   always #2 clk = ~clk;

   ras_ctrl dut (.*);

   int total = 0, bad = 0;
   bit finished = 0;

   // bench model
   int m_stk [8];
   int m_sp = 0;
   bit m_inh = 0;
   bit e_ret_vld = 0, e_jmp_vld = 1, e_ack = 0;
   int e_ret_addr = 0, e_jmp_addr = 0;

   function automatic int vec_target(int v);
      int d = v & 'h7F;
      if (d >= 64) return ('h1FFF & (d - 128));
      return d;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk(tag, "sp", int'(sp_o), m_sp);
      chk(tag, "inh", int'(inh_o), int'(m_inh));
      chk(tag, "ret_vld", int'(ret_vld_o), int'(e_ret_vld));
      if (e_ret_vld) chk(tag, "ret_addr", int'(ret_addr_o), e_ret_addr);
      chk(tag, "jmp_vld", int'(jmp_vld_o), int'(e_jmp_vld));
      if (e_jmp_vld) chk(tag, "jmp_addr", int'(jmp_addr_o), e_jmp_addr);
      chk(tag, "irq_ack", int'(irq_ack_o), int'(e_ack));
   endtask

   task automatic step(bit c, bit r, bit re, int a, bit irqn, bit done,
                       int v, bit sw, int ssp, bit sinh, string tag_in = "");
      string tag;
      @(negedge clk);
      call_req_i = c; ret_req_i = r; ret_en_i = re; link_addr_i = a[14:0];
      irq_n_i = irqn; instr_done_i = done; vec_i = v[7:0];
      sts_wr_i = sw; sts_sp_i = ssp[2:0]; sts_inh_i = sinh;
      e_ret_vld = 0; e_jmp_vld = 0; e_ack = 0;
      if (sw) begin
         tag = "R7"; m_sp = ssp & 7; m_inh = sinh;
      end else if (c) begin
         tag = r ? "R8" : ((m_sp == 7) ? "R3" : "R2");
         m_sp = (m_sp + 1) & 7; m_stk[m_sp] = a & 'h7FFF;
      end else if (r) begin
         tag = re ? "R4" : ((m_sp == 0) ? "R3" : "R2");
         e_ret_vld = 1; e_ret_addr = m_stk[m_sp];
         m_sp = (m_sp + 7) & 7;
         if (re) m_inh = 0;
      end else if (!irqn && !m_inh && done) begin
         tag = "R5";
         m_sp = (m_sp + 1) & 7; m_stk[m_sp] = a & 'h7FFF;
         m_inh = 1; e_jmp_vld = 1; e_ack = 1; e_jmp_addr = vec_target(v);
      end else begin
         tag = "R9";
      end
      if (tag_in != "") tag = tag_in;
      @(posedge clk); #1;
      check_all(tag);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
   endtask

   initial begin
      void'($urandom(32'd2650));
      for (int i = 0; i < 8; i++) m_stk[i] = 0;
      repeat (3) @(posedge clk);
      #1; check_all("R1");           // during reset
      @(negedge clk); rst_n = 1;
      #1; check_all("R1");           // released, before first edge
      e_jmp_vld = 1;
      idle();                        // jump request retires: R9

      // R2 / R3: nine pushes then nine pops, wrapping both ways
      for (int i = 1; i <= 9; i++) step(1, 0, 0, 'h100 + i, 1, 0, 0, 0, 0, 0);
      for (int i = 0; i < 9; i++)  step(0, 1, 0, 0, 1, 0, 0, 0, 0, 0);
      // pop at pointer 0 reads entry 0 then sp=7 (R3)
      step(0, 0, 0, 0, 1, 0, 0, 1, 0, 0, "R7");
      step(0, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R3");

      // R7: load with a simultaneous call: entry must stay untouched
      step(1, 0, 0, 'h7ABC, 0, 1, 3, 1, 2, 0, "R7");
      step(0, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R7");   // pops entry 2, not 0x7ABC
      // R8: call and return together
      step(1, 1, 0, 'h1234, 1, 0, 0, 0, 0, 0, "R8");
      step(0, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R8");

      // R5: inhibit set -> ignored; done low -> ignored
      step(0, 0, 0, 0, 1, 0, 0, 1, 4, 1, "R7");
      step(0, 0, 0, 'h55, 0, 1, 3, 0, 0, 0, "R5");
      step(0, 0, 0, 0, 1, 0, 0, 1, 4, 0, "R7");
      step(0, 0, 0, 'h55, 0, 0, 3, 0, 0, 0, "R5");
      // R5/R6: accepted with vector 3 -> 0x0003
      step(0, 0, 0, 'h0456, 0, 1, 'h03, 0, 0, 0, "R6");
      // R4: plain return keeps inhibit, enable-return clears it
      step(0, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R4");
      step(0, 0, 0, 0, 1, 0, 0, 1, 5, 1, "R7");
      step(0, 1, 1, 0, 1, 0, 0, 0, 0, 0, "R4");
      // R6: bit 7 ignored, negative displacement -> 0x1FC0
      step(0, 0, 0, 'h0777, 0, 1, 'hC0, 0, 0, 0, "R6");
      step(0, 1, 1, 0, 1, 0, 0, 0, 0, 0, "R4");
      step(0, 0, 0, 'h0778, 0, 1, 'h7F, 0, 0, 0, "R6");
      step(0, 1, 1, 0, 1, 0, 0, 0, 0, 0, "R4");

      // constrained random traffic
      for (int n = 0; n < 4000; n++) begin
         int k = $urandom_range(0, 15);
         step(k < 5, (k >= 3 && k < 9), $urandom_range(0, 1) == 1,
              $urandom_range(0, 'h7FFF), $urandom_range(0, 3) != 0,
              $urandom_range(0, 1) == 1, $urandom_range(0, 255),
              k == 15, $urandom_range(0, 7), $urandom_range(0, 3) == 0);
      end
      idle();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule